// File: doc/BRIEF.md
# Mode-Configurable Output Macrocell

This block is one output cell of a sum-of-products logic device. Eight product-term inputs come in from the AND array. The cell combines them with a fixed OR. It then passes the result through an optional D flip-flop and a polarity selector. It produces three outputs: pin data, a pin output enable, and a feedback bit that returns to the array.

Two global mode bits are shared by every cell of the device. They pick one of three modes: simple, complex and registered. Two local bits pick polarity and choose between registered and combinational operation. The cell's position in the device is a parameter. Two positions lose pin feedback in simple mode and two other positions lose it in complex mode.

All cell inputs are plain per-cycle control levels. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure. The combinational outputs follow the inputs within the same cycle. The register changes only on a rising clock edge.

Top module: `sop_out_cell`

## Requirements
- R1: The mode is encoded as {g_mode0, g_mode1}: 2'b10 is simple, 2'b11 is complex, 2'b01 is registered and 2'b00 is reserved. The local bit pol_hi=1 gives active-high data and pol_hi=0 gives active-low (inverted) data.
- R2: In simple mode with comb_sel=0, out_data is the OR of all eight terms, passed through the polarity selector, and out_en is 1.
- R3: In simple mode with comb_sel=1, out_en is 0 and fb equals pin_in. This holds for every position except the simple-mode no-feedback positions.
- R4: In complex mode, out_data is the OR of terms[6:0] with polarity applied. out_en equals terms[7]. fb equals pin_in, except at the complex-mode no-feedback positions.
- R5: In registered mode with comb_sel=0, the flip-flop loads the OR of all eight terms at each rising clock edge. out_data is the flip-flop value with polarity applied, and fb is the flip-flop value.
- R6: In registered mode with comb_sel=0, out_en is the inverse of the active-low oe_n_pin input.
- R7: In registered mode with comb_sel=1, the cell acts as in complex mode: seven ORed terms, enable from terms[7], and fb from pin_in, with no position exceptions.
- R8: With rst high at a rising edge, the flip-flop clears. A registered cell then shows out_data=0 when active-high and out_data=1 when active-low, until its next load.
- R9: At a simple-mode no-feedback position (parameters SIMPLE_NOFB0/1) in simple mode, fb is 0. At a complex-mode no-feedback position (COMPLEX_NOFB0/1) in complex mode, fb is 0.
- R10: In the reserved mode, out_data, out_en and fb are all 0.
- R11: Outside registered mode with comb_sel=0, the flip-flop keeps its value. On returning to that configuration, fb shows the held value before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock (dedicated clock pin) |
| rst | input | 1 | Synchronous clear, models power-up clearing |
| g_mode0 | input | 1 | Global mode bit 0 |
| g_mode1 | input | 1 | Global mode bit 1 |
| pol_hi | input | 1 | Local polarity: 1 active high, 0 active low |
| comb_sel | input | 1 | Local select: 1 combinational / dedicated input, 0 registered / output |
| terms | input | NUM_TERMS | Product terms from the AND array |
| oe_n_pin | input | 1 | Dedicated active-low output-enable pin |
| pin_in | input | 1 | Level present on the cell's I/O pin |
| out_data | output | 1 | Data driven toward the pin |
| out_en | output | 1 | Pin output-enable |
| fb | output | 1 | Feedback into the array |

## Verification
The hardest case to reach from the ports is the flip-flop holding its value while the cell is in a non-registered configuration. The register state is only visible in registered mode with comb_sel=0, so this case needs a planned sequence. The bench loads a 1 into the register, then spends several edges in complex mode with all terms at zero. It then switches back to the registered configuration in a low clock phase and reads fb before the next edge. Random mode and term mixes are also run on two instances. One sits at a simple-mode no-feedback position and the other at a complex-mode one, so the position exceptions are checked under every mode.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;
  // Encoding is {mode0, mode1}
  typedef enum logic [1:0] {
    MODE_RSVD   = 2'b00,
    MODE_REG    = 2'b01,
    MODE_SIMPLE = 2'b10,
    MODE_CPLX   = 2'b11
  } cell_mode_e;

  function automatic cell_mode_e decode_mode(input logic m0, input logic m1);
    return cell_mode_e'({m0, m1});
  endfunction
endpackage

// File: rtl/sop_sum.sv
module sop_sum #(
  parameter int NUM_TERMS = 8
) (
  input  logic [NUM_TERMS-1:0] terms,
  output logic                 sum_all,
  output logic                 sum_less,
  output logic                 ctl_term
);
  localparam int LESS_W = NUM_TERMS - 1;
  logic [LESS_W:0] chain;

  // ripple OR over the data terms; the last term is also offered as a control term
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < LESS_W; i++) begin : g_or
    assign chain[i+1] = chain[i] | terms[i];
  end

  assign sum_less = chain[LESS_W];
  assign ctl_term = terms[NUM_TERMS-1];
  assign sum_all  = sum_less | ctl_term;
endmodule

// File: rtl/cell_reg.sv
module cell_reg (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cell_route.sv
module cell_route
  import sop_cell_pkg::*;
(
  input  cell_mode_e mode,
  input  logic       pol_hi,
  input  logic       comb_sel,
  input  logic       sum_all,
  input  logic       sum_less,
  input  logic       ctl_term,
  input  logic       q,
  input  logic       oe_n_pin,
  input  logic       pin_in,
  input  logic       simple_nofb,
  input  logic       cplx_nofb,
  output logic       out_data,
  output logic       out_en,
  output logic       fb,
  output logic       load
);
  logic raw;

  always_comb begin
    raw  = 1'b0;
    out_en = 1'b0;
    fb   = 1'b0;
    unique case (mode)
      MODE_SIMPLE: begin
        raw    = sum_all;
        out_en = ~comb_sel;
        fb     = simple_nofb ? 1'b0 : pin_in;
      end
      MODE_CPLX: begin
        raw    = sum_less;
        out_en = ctl_term;
        fb     = cplx_nofb ? 1'b0 : pin_in;
      end
      MODE_REG: begin
        if (!comb_sel) begin
          raw    = q;
          out_en = ~oe_n_pin;
          fb     = q;
        end else begin
          raw    = sum_less;
          out_en = ctl_term;
          fb     = pin_in;
        end
      end
      default: begin
        raw    = 1'b0;
        out_en = 1'b0;
        fb     = 1'b0;
      end
    endcase
  end

  assign out_data = (mode == MODE_RSVD) ? 1'b0 : (pol_hi ? raw : ~raw);
  assign load     = (mode == MODE_REG) && !comb_sel;
endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell
  import sop_cell_pkg::*;
#(
  parameter int NUM_TERMS     = 8,
  parameter int CELL_POS      = 0,
  parameter int SIMPLE_NOFB0  = 3,
  parameter int SIMPLE_NOFB1  = 4,
  parameter int COMPLEX_NOFB0 = 0,
  parameter int COMPLEX_NOFB1 = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 g_mode0,
  input  logic                 g_mode1,
  input  logic                 pol_hi,
  input  logic                 comb_sel,
  input  logic [NUM_TERMS-1:0] terms,
  input  logic                 oe_n_pin,
  input  logic                 pin_in,
  output logic                 out_data,
  output logic                 out_en,
  output logic                 fb
);
  localparam logic SIMPLE_NOFB = (CELL_POS == SIMPLE_NOFB0) || (CELL_POS == SIMPLE_NOFB1);
  localparam logic CPLX_NOFB   = (CELL_POS == COMPLEX_NOFB0) || (CELL_POS == COMPLEX_NOFB1);

  cell_mode_e mode;
  logic sum_all, sum_less, ctl_term, q, load;

  assign mode = decode_mode(g_mode0, g_mode1);

  sop_sum #(.NUM_TERMS(NUM_TERMS)) u_sum (
    .terms(terms), .sum_all(sum_all), .sum_less(sum_less), .ctl_term(ctl_term)
  );

  cell_reg u_reg (
    .clk(clk), .rst(rst), .load(load), .d(sum_all), .q(q)
  );

  cell_route u_route (
    .mode(mode), .pol_hi(pol_hi), .comb_sel(comb_sel),
    .sum_all(sum_all), .sum_less(sum_less), .ctl_term(ctl_term),
    .q(q), .oe_n_pin(oe_n_pin), .pin_in(pin_in),
    .simple_nofb(SIMPLE_NOFB), .cplx_nofb(CPLX_NOFB),
    .out_data(out_data), .out_en(out_en), .fb(fb), .load(load)
  );
endmodule

// File: rtl/sop_out_cell_chk.sv
module sop_out_cell_chk #(
  parameter int NUM_TERMS     = 8,
  parameter int CELL_POS      = 0,
  parameter int SIMPLE_NOFB0  = 3,
  parameter int SIMPLE_NOFB1  = 4,
  parameter int COMPLEX_NOFB0 = 0,
  parameter int COMPLEX_NOFB1 = 7
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 g_mode0,
  input logic                 g_mode1,
  input logic                 pol_hi,
  input logic                 comb_sel,
  input logic [NUM_TERMS-1:0] terms,
  input logic                 oe_n_pin,
  input logic                 pin_in,
  input logic                 out_data,
  input logic                 out_en,
  input logic                 fb
);
  logic is_simple, is_cplx, is_reg, is_rsvd, reg_out;
  assign is_simple = g_mode0 && !g_mode1;
  assign is_cplx   = g_mode0 && g_mode1;
  assign is_reg    = !g_mode0 && g_mode1;
  assign is_rsvd   = !g_mode0 && !g_mode1;
  assign reg_out   = is_reg && !comb_sel;

  AST_SIMPLE_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (is_simple && !comb_sel) |-> out_en); // R2

  AST_SIMPLE_INPUT: assert property (@(posedge clk) disable iff (rst)
    (is_simple && comb_sel) |-> !out_en); // R3

  AST_CPLX_ENABLE: assert property (@(posedge clk) disable iff (rst)
    is_cplx |-> (out_en == terms[NUM_TERMS-1])); // R4

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (reg_out && $past(reg_out) && !$past(rst)) |-> (fb == $past(|terms))); // R5

  AST_REG_POLARITY: assert property (@(posedge clk) disable iff (rst)
    reg_out |-> (out_data == (pol_hi ? fb : !fb))); // R5

  AST_REG_OE_PIN: assert property (@(posedge clk) disable iff (rst)
    reg_out |-> (out_en == !oe_n_pin)); // R6

  AST_REGCOMB_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (is_reg && comb_sel) |-> (out_en == terms[NUM_TERMS-1] && fb == pin_in)); // R7

  AST_NOFB_SIMPLE: assert property (@(posedge clk) disable iff (rst)
    (is_simple && (CELL_POS == SIMPLE_NOFB0 || CELL_POS == SIMPLE_NOFB1)) |-> !fb); // R9

  AST_NOFB_CPLX: assert property (@(posedge clk) disable iff (rst)
    (is_cplx && (CELL_POS == COMPLEX_NOFB0 || CELL_POS == COMPLEX_NOFB1)) |-> !fb); // R9

  AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
    is_rsvd |-> (!out_en && !fb && !out_data)); // R10
endmodule

bind sop_out_cell sop_out_cell_chk #(
  .NUM_TERMS(NUM_TERMS), .CELL_POS(CELL_POS),
  .SIMPLE_NOFB0(SIMPLE_NOFB0), .SIMPLE_NOFB1(SIMPLE_NOFB1),
  .COMPLEX_NOFB0(COMPLEX_NOFB0), .COMPLEX_NOFB1(COMPLEX_NOFB1)
) u_chk (
  .clk(clk), .rst(rst), .g_mode0(g_mode0), .g_mode1(g_mode1),
  .pol_hi(pol_hi), .comb_sel(comb_sel), .terms(terms),
  .oe_n_pin(oe_n_pin), .pin_in(pin_in),
  .out_data(out_data), .out_en(out_en), .fb(fb)
);

// File: tb/sop_out_cell_test.sv
module sop_out_cell_test;
  localparam int POS_A = 0;  // complex-mode no-feedback position
  localparam int POS_B = 3;  // simple-mode no-feedback position

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic g_mode0 = 1'b0, g_mode1 = 1'b1, pol_hi = 1'b1, comb_sel = 1'b0;
  logic [7:0] terms = 8'h00;
  logic oe_n_pin = 1'b0, pin_in = 1'b0;
  logic da, ea, fa, db, eb, fbb;
  logic mq;  // bench model of the flip-flop (identical for both cells)
  int tests = 0, fails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sop_out_cell #(.CELL_POS(POS_A)) uut (
    .clk(clk), .rst(rst), .g_mode0(g_mode0), .g_mode1(g_mode1), .pol_hi(pol_hi),
    .comb_sel(comb_sel), .terms(terms), .oe_n_pin(oe_n_pin), .pin_in(pin_in),
    .out_data(da), .out_en(ea), .fb(fa));

  sop_out_cell #(.CELL_POS(POS_B)) uut_b (
    .clk(clk), .rst(rst), .g_mode0(g_mode0), .g_mode1(g_mode1), .pol_hi(pol_hi),
    .comb_sel(comb_sel), .terms(terms), .oe_n_pin(oe_n_pin), .pin_in(pin_in),
    .out_data(db), .out_en(eb), .fb(fbb));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) mq <= 1'b0;
    else if (!g_mode0 && g_mode1 && !comb_sel) mq <= |terms;
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic logic pol(input logic v);
    return pol_hi ? v : ~v;
  endfunction

  // expected-value check of one cell at a given position
  task automatic check_cell(input int pos, input logic d, input logic e, input logic f);
    logic snofb, cnofb;
    snofb = (pos == 3 || pos == 4);
    cnofb = (pos == 0 || pos == 7);
    case ({g_mode0, g_mode1})
      2'b10: begin
        if (!comb_sel) begin
          chk("R2", "data", d, pol(|terms));
          chk("R2", "en", e, 1'b1);
        end else chk("R3", "en", e, 1'b0);
        chk(snofb ? "R9" : "R3", "fb", f, snofb ? 1'b0 : pin_in);
      end
      2'b11: begin
        chk("R4", "data", d, pol(|terms[6:0]));
        chk("R4", "en", e, terms[7]);
        chk(cnofb ? "R9" : "R4", "fb", f, cnofb ? 1'b0 : pin_in);
      end
      2'b01: begin
        if (!comb_sel) begin
          chk("R5", "data", d, pol(mq));
          chk("R5", "fb", f, mq);
          chk("R6", "en", e, ~oe_n_pin);
        end else begin
          chk("R7", "data", d, pol(|terms[6:0]));
          chk("R7", "en", e, terms[7]);
          chk("R7", "fb", f, pin_in);
        end
      end
      default: begin
        chk("R10", "data", d, 1'b0);
        chk("R10", "en", e, 1'b0);
        chk("R10", "fb", f, 1'b0);
      end
    endcase
  endtask

  task automatic settle_check();
    #2;
    check_cell(POS_A, da, ea, fa);
    check_cell(POS_B, db, eb, fbb);
  endtask

  task automatic set_mode(input logic m0, input logic m1, input logic c, input logic p);
    g_mode0 = m0; g_mode1 = m1; comb_sel = c; pol_hi = p;
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R8: clear through reset, registered active-high then active-low
    @(posedge clk); @(posedge clk);
    @(negedge clk); rst = 1'b0; set_mode(1'b0, 1'b1, 1'b0, 1'b1); terms = 8'h00;
    #2 chk("R8", "data active-high after clear", da, 1'b0);
    pol_hi = 1'b0;
    #1 chk("R8", "data active-low after clear", da, 1'b1);
    chk("R8", "fb after clear", fa, 1'b0);
    // R1/R5: load a one, watch it appear after the edge
    pol_hi = 1'b1; terms = 8'h80;
    #1 chk("R5", "fb before edge", fa, 1'b0);
    @(negedge clk); terms = 8'h00;
    #2 chk("R5", "fb after edge loads OR of terms", fa, 1'b1);
    chk("R1", "registered active-high data", da, 1'b1);
    // R6: dedicated enable pin
    oe_n_pin = 1'b1;
    #1 chk("R6", "en with oe_n high", ea, 1'b0);
    oe_n_pin = 1'b0;
    // R11: hold across complex mode
    @(negedge clk); set_mode(1'b1, 1'b1, 1'b0, 1'b1);  // edge above loaded 0? no: terms 0 at that edge
    terms = 8'hFF;
    @(negedge clk); set_mode(1'b0, 1'b1, 1'b0, 1'b1);  // load 1 at next edge
    @(negedge clk); set_mode(1'b1, 1'b1, 1'b0, 1'b1); terms = 8'h00;
    repeat (3) @(negedge clk);
    set_mode(1'b0, 1'b1, 1'b0, 1'b1);
    #2 chk("R11", "held value seen on return", fa, 1'b1);
    @(negedge clk);
    #2 chk("R11", "register reloads after return", fa, 1'b0);
    // R10: reserved mode directed
    set_mode(1'b0, 1'b0, 1'b0, 1'b0); terms = 8'hFF; pin_in = 1'b1;
    #2 chk("R10", "reserved data", da, 1'b0);
    chk("R10", "reserved en", ea, 1'b0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      rst = ($urandom % 16) == 0;
      {g_mode0, g_mode1} = 2'($urandom);
      comb_sel = 1'($urandom);
      pol_hi = 1'($urandom);
      terms = ($urandom % 4 == 0) ? 8'h00 : 8'($urandom >> ($urandom % 8));
      oe_n_pin = 1'($urandom);
      pin_in = 1'($urandom);
      if (!rst) settle_check();
    end
    @(negedge clk);
    rst = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule